// File: doc/BRIEF.md
# Double-Buffered Gamma Lookup Table

This block applies gamma correction to every pixel of a display output pipe. The red, green and blue components of an incoming pixel each address a programmable table. The matching field of the addressed entry replaces that component. A simple write port loads table entries. Control writes set the lookup enable and an update request. A configuration-done strobe commits those settings, and a frame-end strobe marks the boundary where committed settings take effect.

In the default update mode the block holds two table buffers. Software always writes into the inactive (shadow) buffer, so the displayed frame never sees a half-loaded table. A committed update request swaps the buffers at the next frame end. A buffer-index status bit flips when the swap happens, and the request bit clears itself at the same moment. A build-time option instead gives a single-buffer legacy variant. In that variant the table may be loaded only while the lookup is off, and turning the lookup off waits for the frame end.

Top module: `gamma_dbuf_lut`

## Requirements
- R1: The depth parameter DEPTH is either 256 (8-bit components) or 1024 (10-bit components). Any other value stops elaboration. An entry packs red in bits [3W-1:2W], green in [2W-1:W] and blue in [W-1:0], where W is the component width. Input and output pixels use the same field order.
- R2: A table write with byte address A loads entry A[AW-1:2]. A write whose address bits [1:0] are not 00 changes no entry.
- R3: With the lookup in force, the output red equals the red field of entry[input red]. Green and blue follow the same rule, each reading its own entry and its own field.
- R4: The pixel path has exactly one clock of latency. out_valid, out_hsync and out_vsync are in_valid, in_hsync and in_vsync delayed by one clock. While the lookup is not in force, out_pix equals in_pix delayed by one clock.
- R5: A control write (ctrl_wr with ctrl_lut_en and ctrl_upd_req) does not affect the pixel path or lut_en_o until cfg_done commits it. A commit in the same cycle as a control write uses the newly written values.
- R6: A committed enable value reaches lut_en_o, and the pixel path, on the clock after the next frame_end pulse. Until then, lut_en_o keeps its previous value, so a pending disable still reads 1.
- R7: In update mode, table writes go only to the buffer not selected by buf_idx_o. Loading the shadow buffer does not change the output of the active table.
- R8: In update mode, a committed update request is honoured at the first frame_end at which the committed enable is 1. On the clock after that frame_end, buf_idx_o toggles and the freshly loaded buffer drives the lookup.
- R9: upd_req_o reads 1 from the control write that sets it until the swap, and reads 0 from the clock after the swap. A request committed while the committed enable is 0 stays pending, with no toggle.
- R10: In legacy mode (UPDATE_MODE=0), table writes are ignored while lut_en_o is 1, and buf_idx_o stays 0 regardless of update requests.
- R11: After reset, lut_en_o, buf_idx_o, upd_req_o and out_valid are 0. Every buffer holds the identity mapping (entry i = {i,i,i}).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | CW+2 | Byte address inside the table window |
| tbl_wr_data | input | 3*CW | Packed entry {red, green, blue} |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_lut_en | input | 1 | Lookup enable value written by ctrl_wr |
| ctrl_upd_req | input | 1 | Update request value written by ctrl_wr |
| cfg_done | input | 1 | Commit pulse for the written control values |
| frame_end | input | 1 | End-of-frame strobe |
| lut_en_o | output | 1 | Lookup enable currently in force |
| upd_req_o | output | 1 | Update request status, cleared by the swap |
| buf_idx_o | output | 1 | Index of the active table buffer |
| in_valid | input | 1 | Input pixel valid |
| in_hsync | input | 1 | Input horizontal sync |
| in_vsync | input | 1 | Input vertical sync |
| in_pix | input | 3*CW | Input pixel {red, green, blue} |
| out_valid | output | 1 | Output pixel valid |
| out_hsync | output | 1 | Output horizontal sync |
| out_vsync | output | 1 | Output vertical sync |
| out_pix | output | 3*CW | Corrected pixel {red, green, blue} |

## Verification
The bench builds two copies of the block.

The first uses DEPTH=256 in update mode. It reaches the shadow loading of a full table, buffer swaps in both directions, requests held pending while the enable is off, and a control write and commit landing in one cycle.

The second uses DEPTH=1024 in legacy mode. It brings the 10-bit field packing within reach, along with the write lock while the lookup is on and a buffer index that never moves.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

   // component width for a legal table depth
   function automatic int comp_bits(input int depth);
      return (depth == 1024) ? 10 : 8;
   endfunction

   function automatic bit depth_legal(input int depth);
      return (depth == 256) || (depth == 1024);
   endfunction

   // index of each colour field inside a packed entry
   typedef enum int {
      FLD_BLUE  = 0,
      FLD_GREEN = 1,
      FLD_RED   = 2
   } field_e;

   localparam int NUM_FIELDS = 3;

endpackage

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank
   import gamma_lut_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int CW    = comp_bits(DEPTH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [CW-1:0]                waddr,
   input  logic [NUM_FIELDS*CW-1:0]     wdata,
   input  logic [NUM_FIELDS*CW-1:0]     raddr,
   output logic [NUM_FIELDS*CW-1:0]     rdata
);
   localparam int EW = NUM_FIELDS * CW;

   logic [EW-1:0] mem [DEPTH];

   // reset loads the identity curve, writes replace one entry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= {NUM_FIELDS{CW'(i)}};
         end
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   // one read port per colour, each takes its own field of its own entry
   for (genvar c = 0; c < NUM_FIELDS; c++) begin : g_rd
      logic [EW-1:0] entry;
      assign entry = mem[raddr[c*CW +: CW]];
      assign rdata[c*CW +: CW] = entry[c*CW +: CW];
   end

endmodule

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl #(
   parameter bit UPDATE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_wr,
   input  logic ctrl_en,
   input  logic ctrl_upd,
   input  logic cfg_done,
   input  logic frame_end,
   output logic lut_en,
   output logic upd_req,
   output logic buf_idx,
   output logic wr_allow
);
   logic sh_en_q;
   logic sh_upd_q;
   logic pend_en_q;
   logic en_q;
   logic swap;
   logic en_src;

   // a commit in the same cycle as a control write sees the new value
   assign en_src = ctrl_wr ? ctrl_en : sh_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_en_q   <= 1'b0;
         sh_upd_q  <= 1'b0;
         pend_en_q <= 1'b0;
         en_q      <= 1'b0;
      end else begin
         if (ctrl_wr) sh_en_q <= ctrl_en;
         if (swap)         sh_upd_q <= 1'b0;
         else if (ctrl_wr) sh_upd_q <= ctrl_upd;
         if (cfg_done)  pend_en_q <= en_src;
         if (frame_end) en_q      <= pend_en_q;
      end
   end

   assign lut_en  = en_q;
   assign upd_req = sh_upd_q;

   if (UPDATE_MODE) begin : g_upd
      logic pend_upd_q;
      logic idx_q;
      logic upd_src;

      assign upd_src = ctrl_wr ? ctrl_upd : sh_upd_q;
      assign swap    = frame_end & pend_upd_q & pend_en_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_upd_q <= 1'b0;
            idx_q      <= 1'b0;
         end else begin
            if (swap)          pend_upd_q <= 1'b0;
            else if (cfg_done) pend_upd_q <= upd_src;
            if (swap) idx_q <= ~idx_q;
         end
      end

      assign buf_idx  = idx_q;
      assign wr_allow = 1'b1;

      // R8: the active buffer only moves on a frame boundary
      p_idx_at_frame_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (idx_q != $past(idx_q)) |-> $past(frame_end));

      // R9: the request status is gone once the swap has happened
      p_req_clears_on_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (idx_q != $past(idx_q)) |-> !sh_upd_q);

      // R9: a swap needs the committed enable
      p_swap_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (idx_q != $past(idx_q)) |-> en_q);
   end else begin : g_leg
      assign swap     = 1'b0;
      assign buf_idx  = 1'b0;
      assign wr_allow = ~en_q;
   end

   // R6: the enable in force only changes after a frame end
   p_en_at_frame_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q != $past(en_q)) |-> $past(frame_end));

endmodule

// File: rtl/gamma_pix_stage.sv
module gamma_pix_stage #(
   parameter int EW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lut_en,
   input  logic          in_valid,
   input  logic          in_hsync,
   input  logic          in_vsync,
   input  logic [EW-1:0] in_pix,
   input  logic [EW-1:0] map_pix,
   output logic          out_valid,
   output logic          out_hsync,
   output logic          out_vsync,
   output logic [EW-1:0] out_pix
);
   // single register stage shared by the mapped and the bypass path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_hsync <= 1'b0;
         out_vsync <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= in_valid;
         out_hsync <= in_hsync;
         out_vsync <= in_vsync;
         out_pix   <= lut_en ? map_pix : in_pix;
      end
   end

   // R4: control lines keep pace with the pixel
   p_sync_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == $past(in_valid)) && (out_hsync == $past(in_hsync))
      && (out_vsync == $past(in_vsync)));

   // R4: bypass keeps the pixel untouched
   p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!lut_en) |-> (out_pix == $past(in_pix)));

endmodule

// File: rtl/gamma_dbuf_lut.sv
module gamma_dbuf_lut
   import gamma_lut_pkg::*;
#(
   parameter int DEPTH       = 256,
   parameter bit UPDATE_MODE = 1'b1,
   parameter int CW          = comp_bits(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tbl_wr_en,
   input  logic [CW+1:0]           tbl_wr_addr,
   input  logic [NUM_FIELDS*CW-1:0] tbl_wr_data,
   input  logic                    ctrl_wr,
   input  logic                    ctrl_lut_en,
   input  logic                    ctrl_upd_req,
   input  logic                    cfg_done,
   input  logic                    frame_end,
   output logic                    lut_en_o,
   output logic                    upd_req_o,
   output logic                    buf_idx_o,
   input  logic                    in_valid,
   input  logic                    in_hsync,
   input  logic                    in_vsync,
   input  logic [NUM_FIELDS*CW-1:0] in_pix,
   output logic                    out_valid,
   output logic                    out_hsync,
   output logic                    out_vsync,
   output logic [NUM_FIELDS*CW-1:0] out_pix
);
   localparam int EW   = NUM_FIELDS * CW;
   localparam int NBUF = UPDATE_MODE ? 2 : 1;

   // R1: only the two supported depths elaborate
   if (!depth_legal(DEPTH)) begin : g_bad_depth
      $error("gamma_dbuf_lut: DEPTH must be 256 or 1024");
   end
   if (CW != comp_bits(DEPTH)) begin : g_bad_width
      $error("gamma_dbuf_lut: CW must follow DEPTH");
   end

   logic          wr_allow;
   logic          wr_ok;
   logic [CW-1:0] wr_index;
   logic [EW-1:0] map_pix;
   logic [NBUF-1:0] bank_we;
   logic [EW-1:0] bank_rd [NBUF];

   gamma_lut_ctrl #(.UPDATE_MODE(UPDATE_MODE)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (ctrl_wr),
      .ctrl_en   (ctrl_lut_en),
      .ctrl_upd  (ctrl_upd_req),
      .cfg_done  (cfg_done),
      .frame_end (frame_end),
      .lut_en    (lut_en_o),
      .upd_req   (upd_req_o),
      .buf_idx   (buf_idx_o),
      .wr_allow  (wr_allow)
   );

   // word-aligned writes only
   assign wr_index = tbl_wr_addr[CW+1:2];
   assign wr_ok    = tbl_wr_en && (tbl_wr_addr[1:0] == 2'b00) && wr_allow;

   for (genvar b = 0; b < NBUF; b++) begin : g_bank
      if (NBUF == 1) begin : g_single
         assign bank_we[b] = wr_ok;
      end else begin : g_shadow
         // writes land in the buffer that is not on display
         assign bank_we[b] = wr_ok && (buf_idx_o != b[0]);
      end

      gamma_lut_bank #(.DEPTH(DEPTH), .CW(CW)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (bank_we[b]),
         .waddr (wr_index),
         .wdata (tbl_wr_data),
         .raddr (in_pix),
         .rdata (bank_rd[b])
      );
   end

   if (NBUF == 1) begin : g_sel_one
      assign map_pix = bank_rd[0];
   end else begin : g_sel_two
      assign map_pix = buf_idx_o ? bank_rd[1] : bank_rd[0];

      // R7: the buffer on display is never written
      p_shadow_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(bank_we) && !bank_we[buf_idx_o]);
   end

   gamma_pix_stage #(.EW(EW)) u_pix (
      .clk       (clk),
      .rst_n     (rst_n),
      .lut_en    (lut_en_o),
      .in_valid  (in_valid),
      .in_hsync  (in_hsync),
      .in_vsync  (in_vsync),
      .in_pix    (in_pix),
      .map_pix   (map_pix),
      .out_valid (out_valid),
      .out_hsync (out_hsync),
      .out_vsync (out_vsync),
      .out_pix   (out_pix)
   );

endmodule

// File: tb/gamma_dbuf_lut_tb.sv
module gamma_dbuf_lut_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // update-mode copy, 256 x 8-bit
   logic        a_wr = 0, a_cw = 0, a_cen = 0, a_cup = 0, a_cd = 0, a_fe = 0;
   logic [9:0]  a_addr = '0;
   logic [23:0] a_wd = '0;
   logic        a_iv = 0, a_ih = 0, a_ivs = 0;
   logic [23:0] a_ipix = '0;
   logic        a_en, a_upd, a_idx, a_ov, a_oh, a_ovs;
   logic [23:0] a_opix;

   // legacy copy, 1024 x 10-bit
   logic        b_wr = 0, b_cw = 0, b_cen = 0, b_cup = 0, b_cd = 0, b_fe = 0;
   logic [11:0] b_addr = '0;
   logic [29:0] b_wd = '0;
   logic        b_iv = 0;
   logic [29:0] b_ipix = '0;
   logic        b_en, b_upd, b_idx, b_ov, b_oh, b_ovs;
   logic [29:0] b_opix;

   gamma_dbuf_lut #(.DEPTH(256), .UPDATE_MODE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .tbl_wr_en(a_wr), .tbl_wr_addr(a_addr),
      .tbl_wr_data(a_wd), .ctrl_wr(a_cw), .ctrl_lut_en(a_cen),
      .ctrl_upd_req(a_cup), .cfg_done(a_cd), .frame_end(a_fe),
      .lut_en_o(a_en), .upd_req_o(a_upd), .buf_idx_o(a_idx),
      .in_valid(a_iv), .in_hsync(a_ih), .in_vsync(a_ivs), .in_pix(a_ipix),
      .out_valid(a_ov), .out_hsync(a_oh), .out_vsync(a_ovs), .out_pix(a_opix));

   gamma_dbuf_lut #(.DEPTH(1024), .UPDATE_MODE(1'b0)) u_leg (
      .clk(clk), .rst_n(rst_n), .tbl_wr_en(b_wr), .tbl_wr_addr(b_addr),
      .tbl_wr_data(b_wd), .ctrl_wr(b_cw), .ctrl_lut_en(b_cen),
      .ctrl_upd_req(b_cup), .cfg_done(b_cd), .frame_end(b_fe),
      .lut_en_o(b_en), .upd_req_o(b_upd), .buf_idx_o(b_idx),
      .in_valid(b_iv), .in_hsync(1'b0), .in_vsync(1'b0), .in_pix(b_ipix),
      .out_valid(b_ov), .out_hsync(b_oh), .out_vsync(b_ovs), .out_pix(b_opix));

   // bench-side table model of the update-mode copy
   logic [23:0] a_tbl [2][256];
   int          a_act = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] a_data(input int i);
      return {8'(255 - i), 8'(i) ^ 8'h5a, 8'(i * 3)};
   endfunction

   // ---------------- update-mode drivers ----------------
   task automatic a_write(input int i, input logic [23:0] d, input logic [1:0] lo);
      @(negedge clk); a_wr = 1; a_addr = {8'(i), lo}; a_wd = d;
      @(negedge clk); a_wr = 0;
   endtask

   task automatic a_ctrl(input logic en, input logic upd, input logic commit);
      @(negedge clk); a_cw = 1; a_cen = en; a_cup = upd; a_cd = commit;
      @(negedge clk); a_cw = 0; a_cd = 0;
   endtask

   task automatic a_commit();
      @(negedge clk); a_cd = 1;
      @(negedge clk); a_cd = 0;
   endtask

   task automatic a_frame();
      @(negedge clk); a_fe = 1;
      @(negedge clk); a_fe = 0;
   endtask

   task automatic a_pix_chk(input string req, input logic [23:0] p, input logic mapped);
      logic [23:0] e;
      @(negedge clk); a_iv = 1; a_ipix = p;
      @(negedge clk); a_iv = 0;
      e = mapped ? {a_tbl[a_act][p[23:16]][23:16], a_tbl[a_act][p[15:8]][15:8],
                    a_tbl[a_act][p[7:0]][7:0]} : p;
      chk(req, 64'(a_opix), 64'(e));
      chk(req, 64'(a_ov), 64'd1);
   endtask

   // ---------------- legacy drivers ----------------
   task automatic b_write(input int i, input logic [29:0] d);
      @(negedge clk); b_wr = 1; b_addr = {10'(i), 2'b00}; b_wd = d;
      @(negedge clk); b_wr = 0;
   endtask

   task automatic b_ctrl(input logic en, input logic upd);
      @(negedge clk); b_cw = 1; b_cen = en; b_cup = upd; b_cd = 1;
      @(negedge clk); b_cw = 0; b_cd = 0;
      @(negedge clk); b_fe = 1;
      @(negedge clk); b_fe = 0;
   endtask

   task automatic b_pix_chk(input string req, input logic [29:0] p, input logic [29:0] e);
      @(negedge clk); b_iv = 1; b_ipix = p;
      @(negedge clk); b_iv = 0;
      chk(req, 64'(b_opix), 64'(e));
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R11 lut_en after reset", 64'(a_en), 0);
      chk("R11 buf_idx after reset", 64'(a_idx), 0);
      chk("R11 upd_req after reset", 64'(a_upd), 0);
      chk("R11 out_valid after reset", 64'(a_ov), 0);
      a_pix_chk("R4 bypass while disabled", 24'h123456, 1'b0);
   endtask

   task automatic t_sync();
      @(negedge clk); a_iv = 1; a_ih = 1; a_ivs = 0;
      @(negedge clk);
      chk("R4 sync delay step1", {61'd0, a_ov, a_oh, a_ovs}, 64'b110);
      a_iv = 0; a_ih = 0; a_ivs = 1;
      @(negedge clk);
      chk("R4 sync delay step2", {61'd0, a_ov, a_oh, a_ovs}, 64'b001);
      a_ivs = 0;
      @(negedge clk);
   endtask

   task automatic t_commit();
      a_ctrl(1'b1, 1'b0, 1'b0);
      a_frame();
      chk("R5 uncommitted enable ignored", 64'(a_en), 0);
      a_commit();
      chk("R6 committed enable waits for frame end", 64'(a_en), 0);
      a_frame();
      chk("R6 enable after frame end", 64'(a_en), 1);
      a_pix_chk("R11 identity table", 24'ha53c0f, 1'b1);
   endtask

   task automatic t_shadow();
      for (int i = 0; i < 256; i++) begin
         a_write(i, a_data(i), 2'b00);
         a_tbl[1 - a_act][i] = a_data(i);
      end
      a_write(5, 24'hffffff, 2'b01);
      a_pix_chk("R7 shadow load leaves active table", 24'h0580ff, 1'b1);
      chk("R7 index unchanged by loading", 64'(a_idx), 0);
   endtask

   task automatic t_swap();
      a_ctrl(1'b1, 1'b1, 1'b0);
      chk("R9 request reads back", 64'(a_upd), 1);
      a_commit();
      chk("R8 no swap before frame end", 64'(a_idx), 0);
      a_frame();
      a_act = 1 - a_act;
      chk("R8 index toggled", 64'(a_idx), 1);
      chk("R9 request self-cleared", 64'(a_upd), 0);
      a_pix_chk("R2 misaligned write ignored", 24'h050505, 1'b1);
      a_pix_chk("R3 per-component lookup", 24'h00ff80, 1'b1);
      a_pix_chk("R8 new table active", 24'hff0001, 1'b1);
   endtask

   task automatic t_disable();
      a_ctrl(1'b0, 1'b0, 1'b1);
      chk("R6 pending disable still reads 1", 64'(a_en), 1);
      a_pix_chk("R6 mapping kept until frame end", 24'h7f2010, 1'b1);
      a_frame();
      chk("R6 disable after frame end", 64'(a_en), 0);
      a_pix_chk("R4 bypass after disable", 24'h7f2010, 1'b0);
   endtask

   task automatic t_pending();
      a_ctrl(1'b0, 1'b1, 1'b1);
      a_frame();
      chk("R9 request held while disabled", 64'(a_upd), 1);
      chk("R9 no swap while disabled", 64'(a_idx), 1);
      a_ctrl(1'b1, 1'b1, 1'b1);
      a_frame();
      a_act = 1 - a_act;
      chk("R8 swap back to identity buffer", 64'(a_idx), 0);
      chk("R5 same-cycle write and commit enable", 64'(a_en), 1);
      chk("R9 request cleared after second swap", 64'(a_upd), 0);
      a_pix_chk("R8 identity buffer in use", 24'h3c9912, 1'b1);
   endtask

   task automatic t_legacy();
      b_write(3, {10'd7, 10'd500, 10'd1023});
      b_ctrl(1'b1, 1'b1);
      chk("R10 legacy enable", 64'(b_en), 1);
      chk("R10 legacy index fixed", 64'(b_idx), 0);
      b_pix_chk("R1 ten-bit field packing", {10'd3, 10'd3, 10'd3}, {10'd7, 10'd500, 10'd1023});
      b_write(3, 30'd0);
      b_pix_chk("R10 write ignored while enabled", {10'd3, 10'd3, 10'd3}, {10'd7, 10'd500, 10'd1023});
      b_pix_chk("R1 identity at top entry", {10'd1000, 10'd1023, 10'd0}, {10'd1000, 10'd1023, 10'd0});
      b_ctrl(1'b0, 1'b0);
      b_write(3, {10'd9, 10'd8, 10'd6});
      b_ctrl(1'b1, 1'b0);
      chk("R10 legacy index after second frame", 64'(b_idx), 0);
      b_pix_chk("R10 write accepted while disabled", {10'd3, 10'd3, 10'd3}, {10'd9, 10'd8, 10'd6});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < 256; i++)
            a_tbl[b][i] = {3{8'(i)}};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sync();
      t_commit();
      t_shadow();
      t_swap();
      t_disable();
      t_pending();
      t_legacy();
      finish_run();
   end

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

endmodule